// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the divider settings of a clock synthesizer: a 9-bit feedback divide value, a 3-bit output divider code and a 2-bit test-select field. The settings come in over one of two paths. In the pin path, a parallel bus is passed straight through to the active settings while an active-low load strobe is held low. The value that is present when the strobe rises is then held. In the serial path, a data/clock/load trio fills a 14-bit shift register and copies it into the active settings.

Every strobe, serial line and parallel pin is brought into the system clock domain through a two-stage synchronizer. Edges are found on the synchronized copies, so the block reacts a fixed three system clocks after a change at its pins. A test output picks one of several internal signals by the test-select field. A status flag reports when the feedback value lies outside the range in which the loop can lock.

Top module: `divCfgTop`

## Requirements
- R1: While `rstN` is low, `mValue`, `nCode` and `tSel` are 0, `testOut` is 0 and `mOutOfRange` is 1.
- R2: While `parLoadN` is low, `mValue` and `nCode` follow `mPin` and `nPin`, with a latency of three system clocks.
- R3: Once `parLoadN` is high, later changes on `mPin` and `nPin` have no effect on `mValue` and `nCode`.
- R4: While `parLoadN` is high, each rising edge of `serClk` shifts `serData` into the shift register. While `serLoad` stays low, the active settings do not change.
- R5: A frame is 14 bits, sent first bit first: the two test-select bits (high bit first), then the output code (high bit first), then the feedback value (bit 8 first, bit 0 last). After `serLoad` rises, `tSel` holds the first two bits, `nCode` the next three and `mValue` the last nine.
- R6: While `serLoad` is high in serial mode, the active settings track the shift register, so each new `serClk` edge updates them. After `serLoad` falls, they hold.
- R7: In serial mode, `testOut` is chosen by `tSel`: 0 gives constant 0, 1 gives the synchronized `serData`, 2 gives `fbDivMon`, and 3 gives `synthOutMon`.
- R8: While `parLoadN` is low, `testOut` is 0 whatever `tSel` holds.
- R9: `holdReset` forces `testOut` to 0 and leaves `mValue`, `nCode` and `tSel` unchanged.
- R10: `mOutOfRange` is 1 exactly when `mValue` is below 100 or above 350.
- R11: Parallel loading never changes `tSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset of synchronizers and settings |
| parLoadN | input | 1 | Pin-path load strobe, active low (low = transparent) |
| mPin | input | 9 | Parallel feedback divide value |
| nPin | input | 3 | Parallel output divider code |
| serClk | input | 1 | Serial shift clock (sampled) |
| serData | input | 1 | Serial data |
| serLoad | input | 1 | Serial load strobe |
| holdReset | input | 1 | Divider reset; blanks the test output only |
| fbDivMon | input | 1 | Feedback divider output to monitor |
| synthOutMon | input | 1 | Synthesized clock to monitor |
| mValue | output | 9 | Active feedback divide value |
| nCode | output | 3 | Active output divider code |
| tSel | output | 2 | Active test-select field |
| testOut | output | 1 | Test monitor output |
| mOutOfRange | output | 1 | Feedback value outside the lockable range |

## Verification
On every cycle, the bound assertions check several things. Pin-path transparency is checked against the synchronized pins. The active settings must hold when neither load path is open, and must track the shift register while the serial strobe is high. The test output must be low in parallel mode or under the divider reset, and parallel mode must leave the test-select field untouched. Some properties are visible only from the bench's scenarios. These include the bit order of a whole frame, the selection made by each test-select code, the latching of a value at the strobe edges, and the range flag at its limits. The bench covers these by driving complete frames and comparing against a behavioural model on every clock.

// File: rtl/div_cfg_pkg.sv
package div_cfg_pkg;
  localparam int M_W = 9;
  localparam int N_W = 3;
  localparam int T_W = 2;
  localparam int FRAME_W = T_W + N_W + M_W;

  typedef struct packed {
    logic passPins;   // pin path transparent
    logic shiftBit;   // take one serial bit
    logic takeShift;  // copy shift register into active settings
  } cfgStrobe_t;
endpackage

// File: rtl/cfgSync.sv
module cfgSync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/cfgControl.sv
module cfgControl
  import div_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       parS,
  input  logic       serClkS,
  input  logic       serLoadS,
  output cfgStrobe_t strobe
);
  logic serClkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serClkQ <= 1'b0;
    else       serClkQ <= serClkS;
  end

  always_comb begin
    strobe.passPins  = !parS;
    strobe.shiftBit  = parS && serClkS && !serClkQ;
    strobe.takeShift = parS && serLoadS;
  end
endmodule

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import div_cfg_pkg::*;
#(
  parameter int M_MIN = 100,
  parameter int M_MAX = 350
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic               serDataS,
  input  logic [M_W-1:0]     mPinS,
  input  logic [N_W-1:0]     nPinS,
  input  logic               holdReset,
  input  logic               fbDivMon,
  input  logic               synthOutMon,
  output logic [FRAME_W-1:0] shiftWord,
  output logic [M_W-1:0]     mValue,
  output logic [N_W-1:0]     nCode,
  output logic [T_W-1:0]     tSel,
  output logic               testOut,
  output logic               mOutOfRange
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      mValue    <= '0;
      nCode     <= '0;
      tSel      <= '0;
    end else begin
      if (strobe.shiftBit) shiftWord <= {shiftWord[FRAME_W-2:0], serDataS};
      if (strobe.passPins) begin
        mValue <= mPinS;
        nCode  <= nPinS;
      end else if (strobe.takeShift) begin
        {tSel, nCode, mValue} <= shiftWord;
      end
    end
  end

  always_comb begin
    testOut = 1'b0;
    if (!strobe.passPins && !holdReset) begin
      unique case (tSel)
        2'd0: testOut = 1'b0;
        2'd1: testOut = serDataS;
        2'd2: testOut = fbDivMon;
        default: testOut = synthOutMon;
      endcase
    end
  end

  assign mOutOfRange = (int'(mValue) < M_MIN) || (int'(mValue) > M_MAX);
endmodule

// File: rtl/divCfgTop.sv
module divCfgTop
  import div_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_MIN = 100,
  parameter int M_MAX = 350
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           parLoadN,
  input  logic [M_W-1:0] mPin,
  input  logic [N_W-1:0] nPin,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic           holdReset,
  input  logic           fbDivMon,
  input  logic           synthOutMon,
  output logic [M_W-1:0] mValue,
  output logic [N_W-1:0] nCode,
  output logic [T_W-1:0] tSel,
  output logic           testOut,
  output logic           mOutOfRange
);
  localparam int PIN_W = M_W + N_W;

  logic parS, serClkS, serDataS, serLoadS;
  logic [M_W-1:0] mPinS;
  logic [N_W-1:0] nPinS;
  logic [FRAME_W-1:0] shiftWord;
  cfgStrobe_t strobe;

  cfgSync #(.W(4), .STAGES(SYNC_STAGES)) i_ctlSync (
    .clk(clk), .rstN(rstN),
    .din({parLoadN, serClk, serData, serLoad}),
    .dout({parS, serClkS, serDataS, serLoadS})
  );

  cfgSync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_pinSync (
    .clk(clk), .rstN(rstN),
    .din({mPin, nPin}),
    .dout({mPinS, nPinS})
  );

  cfgControl i_ctl (
    .clk(clk), .rstN(rstN), .parS(parS), .serClkS(serClkS),
    .serLoadS(serLoadS), .strobe(strobe)
  );

  cfgDatapath #(.M_MIN(M_MIN), .M_MAX(M_MAX)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serDataS(serDataS),
    .mPinS(mPinS), .nPinS(nPinS), .holdReset(holdReset),
    .fbDivMon(fbDivMon), .synthOutMon(synthOutMon),
    .shiftWord(shiftWord), .mValue(mValue), .nCode(nCode), .tSel(tSel),
    .testOut(testOut), .mOutOfRange(mOutOfRange)
  );
endmodule

// File: rtl/divCfgChecker.sv
module divCfgChecker
  import div_cfg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               parS,
  input logic               serLoadS,
  input logic               holdReset,
  input logic [M_W-1:0]     mPinS,
  input logic [FRAME_W-1:0] shiftWord,
  input logic [M_W-1:0]     mValue,
  input logic [N_W-1:0]     nCode,
  input logic [T_W-1:0]     tSel,
  input logic               testOut
);
  assert_pin_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(parS) |-> mValue == $past(mPinS));

  assert_settings_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(parS) && !$past(serLoadS)) |-> ($stable(mValue) && $stable(nCode) && $stable(tSel)));

  assert_serial_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(parS) && $past(serLoadS)) |-> {tSel, nCode, mValue} == $past(shiftWord));

  assert_test_low_parallel_R8: assert property (@(posedge clk) disable iff (!rstN)
    !parS |-> !testOut);

  assert_test_low_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    holdReset |-> !testOut);

  assert_tsel_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(parS) |-> $stable(tSel));
endmodule

bind divCfgTop divCfgChecker i_divCfgChecker (
  .clk(clk), .rstN(rstN), .parS(parS), .serLoadS(serLoadS),
  .holdReset(holdReset), .mPinS(mPinS), .shiftWord(shiftWord),
  .mValue(mValue), .nCode(nCode), .tSel(tSel), .testOut(testOut)
);

// File: tb/test_divCfgTop.sv
module test_divCfgTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic parLoadN = 1'b0;
  logic [8:0] mPin = '0;
  logic [2:0] nPin = '0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic holdReset = 1'b0, fbDivMon = 1'b0, synthOutMon = 1'b0;
  logic [8:0] mValue;
  logic [2:0] nCode;
  logic [1:0] tSel;
  logic testOut, mOutOfRange;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  divCfgTop i_divCfgTop (
    .clk(clk), .rstN(rstN), .parLoadN(parLoadN), .mPin(mPin), .nPin(nPin),
    .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .holdReset(holdReset), .fbDivMon(fbDivMon), .synthOutMon(synthOutMon),
    .mValue(mValue), .nCode(nCode), .tSel(tSel), .testOut(testOut),
    .mOutOfRange(mOutOfRange)
  );

  // Behavioural reference: history of sampled pins, pins seen three edges late.
  // Packing: [15] load strobe, [14] serial clock, [13] serial data,
  // [12] serial load, [11:3] feedback pins, [2:0] output code pins.
  logic [15:0] hist [3];
  logic [13:0] mdlShift;
  int mdlM, mdlN, mdlT;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) hist[i] = '0;
      mdlShift = '0; mdlM = 0; mdlN = 0; mdlT = 0;
    end else begin
      logic [15:0] cur, prv;
      cur = hist[1];
      prv = hist[2];
      if (!cur[15]) begin
        mdlM = int'(cur[11:3]);
        mdlN = int'(cur[2:0]);
      end else if (cur[12]) begin
        mdlT = int'(mdlShift[13:12]);
        mdlN = int'(mdlShift[11:9]);
        mdlM = int'(mdlShift[8:0]);
      end
      if (cur[15] && cur[14] && !prv[14]) mdlShift = {mdlShift[12:0], cur[13]};
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = {parLoadN, serClk, serData, serLoad, mPin, nPin};
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      int expTest;
      expTest = 0;
      if (hist[1][15] && !holdReset) begin
        case (mdlT)
          1: expTest = int'(hist[1][13]);
          2: expTest = int'(fbDivMon);
          3: expTest = int'(synthOutMon);
          default: expTest = 0;
        endcase
      end
      check("model mValue R2 R5 R6", int'(mValue), mdlM);
      check("model nCode R2 R5 R6", int'(nCode), mdlN);
      check("model tSel R5 R11", int'(tSel), mdlT);
      check("model testOut R7 R8 R9", int'(testOut), expTest);
      check("model mOutOfRange R10", int'(mOutOfRange), int'(mdlM < 100 || mdlM > 350));
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendBits(logic [13:0] bits, int count);
    for (int i = count - 1; i >= 0; i--) begin
      serData = bits[i];
      waitCyc(4);
      serClk = 1'b1;
      waitCyc(4);
      serClk = 1'b0;
      waitCyc(4);
    end
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    waitCyc(5);
    serLoad = 1'b0;
    waitCyc(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 mValue", int'(mValue), 0);
    check("R1 tSel", int'(tSel), 0);
    check("R1 testOut", int'(testOut), 0);
    check("R1 mOutOfRange", int'(mOutOfRange), 1);
    @(posedge clk); #1;
    rstN = 1'b1;
    waitCyc(2);

    // R2: transparent pin path
    mPin = 9'd200; nPin = 3'd3;
    waitCyc(4);
    check("R2 mValue", int'(mValue), 200);
    check("R2 nCode", int'(nCode), 3);
    check("R10 in range", int'(mOutOfRange), 0);
    mPin = 9'd99;
    waitCyc(4);
    check("R10 below 100", int'(mOutOfRange), 1);
    mPin = 9'd100;
    waitCyc(4);
    check("R10 at 100", int'(mOutOfRange), 0);
    mPin = 9'd200;
    waitCyc(4);

    // R3: capture on strobe rise
    parLoadN = 1'b1;
    waitCyc(4);
    mPin = 9'd7; nPin = 3'd6;
    waitCyc(6);
    check("R3 mValue held", int'(mValue), 200);
    check("R3 nCode held", int'(nCode), 3);

    // R4, R5: frame T=01 N=5 M=421 shifted with load strobe low
    sendBits({2'b01, 3'd5, 9'd421}, 14);
    check("R4 mValue unchanged while shifting", int'(mValue), 200);
    pulseLoad();
    check("R5 tSel", int'(tSel), 1);
    check("R5 nCode", int'(nCode), 5);
    check("R5 mValue", int'(mValue), 421);
    check("R10 above 350", int'(mOutOfRange), 1);

    // R6: hold after strobe fall, follow while strobe high
    sendBits(14'h0, 2);
    check("R6 held after fall", int'(mValue), 421);
    sendBits({2'b01, 3'd5, 9'd421}, 14);
    serLoad = 1'b1;
    waitCyc(5);
    sendBits(14'h1, 1);
    check("R6 follow mValue", int'(mValue), 331);
    check("R6 follow nCode", int'(nCode), 3);
    check("R6 follow tSel", int'(tSel), 3);
    serLoad = 1'b0;
    waitCyc(5);

    // R7: test output selection, tSel=3 first
    synthOutMon = 1'b1;
    waitCyc(1);
    check("R7 sel3 high", int'(testOut), 1);
    synthOutMon = 1'b0;
    waitCyc(1);
    check("R7 sel3 low", int'(testOut), 0);

    // R9: divider reset blanks test output, keeps settings
    synthOutMon = 1'b1;
    holdReset = 1'b1;
    waitCyc(2);
    check("R9 testOut blanked", int'(testOut), 0);
    check("R9 mValue kept", int'(mValue), 331);
    holdReset = 1'b0;
    waitCyc(2);
    check("R9 testOut back", int'(testOut), 1);

    sendBits({2'b10, 3'd2, 9'd300}, 14);
    pulseLoad();
    fbDivMon = 1'b1;
    waitCyc(1);
    check("R7 sel2", int'(testOut), 1);
    fbDivMon = 1'b0;
    waitCyc(1);
    check("R7 sel2 low", int'(testOut), 0);

    sendBits({2'b01, 3'd1, 9'd150}, 14);
    pulseLoad();
    serData = 1'b1;
    waitCyc(4);
    check("R7 sel1 data high", int'(testOut), 1);
    serData = 1'b0;
    waitCyc(4);
    check("R7 sel1 data low", int'(testOut), 0);

    sendBits({2'b00, 3'd1, 9'd150}, 14);
    pulseLoad();
    synthOutMon = 1'b1; fbDivMon = 1'b1; serData = 1'b1;
    waitCyc(4);
    check("R7 sel0 low", int'(testOut), 0);

    // R8, R11: back to parallel mode with tSel=3
    sendBits({2'b11, 3'd1, 9'd150}, 14);
    pulseLoad();
    check("R7 sel3 reloaded", int'(testOut), 1);
    parLoadN = 1'b0;
    mPin = 9'd351; nPin = 3'd4;
    waitCyc(5);
    check("R8 testOut low in parallel", int'(testOut), 0);
    check("R11 tSel kept", int'(tSel), 3);
    check("R2 mValue again", int'(mValue), 351);
    check("R10 at 351", int'(mOutOfRange), 1);
    mPin = 9'd350;
    waitCyc(4);
    check("R10 at 350", int'(mOutOfRange), 0);
    parLoadN = 1'b1;
    waitCyc(5);
    check("R8 serial again", int'(testOut), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule